// File: doc/BRIEF.md
# Quad Periodic Down-Counter Timer

This block holds four independent down-counting timers of 32 bits behind a small register port. All four count on a shared tick strobe. The tick is a one-cycle enable at 1 MHz, so the system clock can be any integer multiple of 1 MHz. Each timer has a reload value (its length) and a count that software can read back. One control word starts or stops all four timers at once. Each timer drives its own interrupt level when it expires and then reloads, so it runs periodically.

The same register space holds a trigger register. Writing one exact magic word to it produces a one-cycle system reset request. The register port is synchronous. A write takes effect at the clock edge that samples `wr_en_i`. Read data appears on `rdata_o` one cycle after `rd_en_i`, and the port returns zero in any cycle without a read.

Top module: `qtmr_top`

## Requirements
- R1: After the synchronous reset, every length and count is zero, all timers are stopped, every `irq_o` bit is 0 and `sys_rst_req_o` is 0.
- R2: A write of a nonzero value to the length register of timer i (byte offset 4*i, i = 0..3) stores the value as the reload value and loads the count with it. The timer's run state does not change.
- R3: A write of zero to a length register stores zero, stops that timer and clears its count to zero.
- R4: A write to the control register at offset 0x10 treats bits [4i+3:4i] as the field of timer i. If the field is nonzero and the length of timer i is nonzero, the timer loads its count from its length and runs. Otherwise the timer stops and keeps its count.
- R5: On each cycle with `tick_en_i` high, a running timer whose count is above 1 decrements its count. A running timer whose count is 1 expires: it reloads its length, so the period is length ticks.
- R6: When a timer expires, its `irq_o` bit goes high and stays high. A write to that timer's length register or to the control register clears it. A register write that lands in the same cycle as a tick takes priority over the tick.
- R7: `sys_rst_req_o` is high for exactly the cycle after a write of 0x00010000 to offset 0x34. Any other value written there has no effect.
- R8: A read returns the count of timer i at offset 0x14 + 4*i. A read of any other offset, including the length and control registers, returns zero.
- R9: A stopped timer, or any timer while `tick_en_i` is low, keeps its count unless a register write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | One-cycle count strobe at 1 MHz |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after `rd_en_i` |
| irq_o | output | 4 | Expiry interrupt level, one bit per timer |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench targets several corner cases:
- A length of 1, which must expire on every tick. An off-by-one reload would expire every other tick or never.
- A control field that is set for a timer whose length is zero. A design that ignores the zero length would start a timer that counts down from zero and wraps.
- A write and a tick in the same cycle. A wrong priority either loses the interrupt clear or decrements a freshly loaded count.
- Near-miss values at the reset trigger, and reads of the length and control offsets. A loose decode would fire the reset request, or leak register contents onto the read port.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  localparam int QT_STRIDE = 4;           // bytes between registers
  localparam int QT_FIELD  = 4;           // control bits per timer
  localparam logic [31:0] QT_RST_MAGIC = 32'h0001_0000;
  localparam int QT_RST_OFFSET = 'h34;
endpackage

// File: rtl/qtmr_chan.sv
module qtmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          len_we_i,
  input  logic          ctl_we_i,
  input  logic          ctl_go_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] count_o,
  output logic          irq_o
);
  logic [DW-1:0] len_q;
  logic [DW-1:0] cnt_q;
  logic          run_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (len_we_i) begin
      len_q <= wdata_i;
      irq_q <= 1'b0;
      if (wdata_i == '0) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= wdata_i;
      end
    end else if (ctl_we_i) begin
      irq_q <= 1'b0;
      if (ctl_go_i && (len_q != '0)) begin
        cnt_q <= len_q;
        run_q <= 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end else if (tick_i && run_q) begin
      if (cnt_q <= DW'(1)) begin
        cnt_q <= len_q;
        irq_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - DW'(1);
      end
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  // R4: a running timer always has a nonzero length
  a_r4_run_needs_len: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (len_q != '0));
  // R5: a running count stays within 1..length
  a_r5_count_range: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0 && cnt_q <= len_q));
  // R6: the interrupt rises only after a tick on a running timer
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(tick_i && run_q));
  // R9: a stopped timer without a write holds its count
  a_r9_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!$past(run_q) && !$past(len_we_i) && !$past(ctl_we_i)) |-> $stable(cnt_q));
endmodule

// File: rtl/qtmr_regs.sv
module qtmr_regs
  import qtmr_pkg::*;
#(
  parameter int NT = 4,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NT-1:0][DW-1:0] count_i,
  output logic [NT-1:0]         len_we_o,
  output logic                  ctl_we_o,
  output logic [NT-1:0]         ctl_go_o,
  output logic [DW-1:0]         rdata_o
);
  localparam int CTL_OFF = QT_STRIDE * NT;
  localparam int CNT_OFF = CTL_OFF + QT_STRIDE;

  logic [DW-1:0] rd_next;
  logic          cnt_hit;
  logic [DW-1:0] rdata_q;

  assign ctl_we_o = wr_en_i && (addr_i == AW'(CTL_OFF));

  for (genvar g = 0; g < NT; g++) begin : g_dec
    assign len_we_o[g] = wr_en_i && (addr_i == AW'(QT_STRIDE * g));
    assign ctl_go_o[g] = |wdata_i[QT_FIELD*g +: QT_FIELD];
  end

  always_comb begin
    rd_next = '0;
    cnt_hit = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (addr_i == AW'(CNT_OFF + QT_STRIDE * i)) begin
        rd_next = count_i[i];
        cnt_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en_i ? rd_next : '0;
  end

  assign rdata_o = rdata_q;

  // R8: reads outside the count window give zero
  a_r8_other_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !cnt_hit) |=> (rdata_q == '0));
endmodule

// File: rtl/qtmr_rstreq.sv
module qtmr_rstreq
  import qtmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= wr_en_i && (addr_i == AW'(QT_RST_OFFSET))
                      && (wdata_i == DW'(QT_RST_MAGIC));
  end

  assign req_o = req_q;

  // R7: a request only follows the exact magic write
  a_r7_req_cause: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(wr_en_i && addr_i == AW'(QT_RST_OFFSET) && wdata_i == DW'(QT_RST_MAGIC)));
endmodule

// File: rtl/qtmr_top.sv
module qtmr_top #(
  parameter int NT = 4,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NT-1:0] irq_o,
  output logic          sys_rst_req_o
);
  logic [NT-1:0][DW-1:0] count;
  logic [NT-1:0]         len_we;
  logic [NT-1:0]         ctl_go;
  logic                  ctl_we;

  qtmr_regs #(.NT(NT), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(count),
    .len_we_o(len_we), .ctl_we_o(ctl_we), .ctl_go_o(ctl_go),
    .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    qtmr_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst), .tick_i(tick_en_i),
      .len_we_i(len_we[g]), .ctl_we_i(ctl_we), .ctl_go_i(ctl_go[g]),
      .wdata_i(wdata_i), .count_o(count[g]), .irq_o(irq_o[g])
    );
  end

  qtmr_rstreq #(.DW(DW), .AW(AW)) u_rstreq (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .req_o(sys_rst_req_o)
  );
endmodule

// File: tb/qtmr_top_tb.sv
module qtmr_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        rreq;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  logic [31:0] m_len [4];
  logic [31:0] m_cnt [4];
  logic        m_run [4];
  logic [3:0]  m_irq;
  logic [31:0] m_rdata;
  logic        m_rreq;

  always #2.5 clk = ~clk;

  qtmr_top u_dut (
    .clk(clk), .rst(rst), .tick_en_i(tick), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sys_rst_req_o(rreq)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a);
    for (int i = 0; i < 4; i++)
      if (a == 8'(8'h14 + 4 * i)) return m_cnt[i];
    return 32'h0;
  endfunction

  task automatic model_step();
    m_rdata = rd ? exp_read(addr) : 32'h0;
    m_rreq  = wr && addr == 8'h34 && wdata == 32'h0001_0000;
    for (int i = 0; i < 4; i++) begin
      if (rst) begin
        m_len[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_irq[i] = 0;
      end else if (wr && addr == 8'(4 * i)) begin
        m_len[i] = wdata; m_irq[i] = 0;
        if (wdata == 0) begin m_run[i] = 0; m_cnt[i] = 0; end
        else m_cnt[i] = wdata;
      end else if (wr && addr == 8'h10) begin
        m_irq[i] = 0;
        if (wdata[4*i +: 4] != 0 && m_len[i] != 0) begin
          m_cnt[i] = m_len[i]; m_run[i] = 1;
        end else m_run[i] = 0;
      end else if (tick && m_run[i]) begin
        if (m_cnt[i] <= 1) begin m_cnt[i] = m_len[i]; m_irq[i] = 1; end
        else m_cnt[i] = m_cnt[i] - 1;
      end
    end
    if (rst) begin m_rdata = 0; m_rreq = 0; end
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    #0.5;
    model_step();
    @(negedge clk);
    check("irq", 32'(irq), 32'(m_irq));
    check("rst_req", 32'(rreq), 32'(m_rreq));
    check("rdata", rdata, m_rdata);
    wr = 0; rd = 0; tick = 0;
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d; step();
  endtask

  task automatic do_rd(logic [7:0] a);
    rd = 1; addr = a; step();
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin tick = 1; step(); end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      m_len[i] = 0; m_cnt[i] = 0; m_run[i] = 0;
    end
    m_irq = 0;
    @(negedge clk);
    step(); step(); step();
    rst = 0;
    // R1: reset state
    tag = "R1";
    step();
    for (int i = 0; i < 4; i++) do_rd(8'(8'h14 + 4 * i));
    // R2: length load
    tag = "R2";
    do_wr(8'h00, 32'd5);
    do_rd(8'h14);
    do_wr(8'h08, 32'd1);
    do_rd(8'h1C);
    // R4: start timer 0 and 2; timer 1 has length zero so must stay stopped
    tag = "R4";
    do_wr(8'h10, 32'h0000_0370);
    do_wr(8'h10, 32'h0000_0F1A);
    ticks(1);
    do_rd(8'h18);
    // R5: periodic countdown; timer 2 length 1 expires each tick
    tag = "R5";
    ticks(4);
    do_rd(8'h14);
    // R6: irq held without ticks, then cleared by a control write
    tag = "R6";
    step(); step();
    do_wr(8'h10, 32'h0000_0001);
    ticks(5);
    // write and tick in the same cycle: write wins
    tick = 1; do_wr(8'h00, 32'd3);
    // R9: no tick keeps count
    tag = "R9";
    step(); step();
    do_rd(8'h14);
    // R3: zero length stops and clears
    tag = "R3";
    do_wr(8'h00, 32'd0);
    ticks(3);
    do_rd(8'h14);
    // R7: reset trigger
    tag = "R7";
    do_wr(8'h34, 32'h0001_0000);
    step();
    do_wr(8'h34, 32'h0001_0001);
    do_wr(8'h34, 32'h0000_0000);
    do_wr(8'h30, 32'h0001_0000);
    // R8: other offsets read zero
    tag = "R8";
    do_wr(8'h04, 32'd9);
    do_rd(8'h04); do_rd(8'h10); do_rd(8'h34); do_rd(8'h24); do_rd(8'h16);
    // random mix
    tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      tick = ($urandom_range(0, 1) == 1);
      if (sel < 2) begin
        wr = 1; addr = 8'(4 * $urandom_range(0, 3));
        wdata = 32'($urandom_range(0, 6));
      end else if (sel == 2) begin
        wr = 1; addr = 8'h10; wdata = $urandom & 32'hFFFF;
      end else if (sel < 7) begin
        rd = 1; addr = 8'(8'h14 + 4 * $urandom_range(0, 4));
      end
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule